// File: doc/BRIEF.md
# Serial Port Status Register with Read-Armed Flag Clearing

This block keeps the eight status bits of a serial communication interface. Hardware pulses from the transmitter and receiver set the flags: transmit buffer handed to the shifter, receive complete, receive overrun, framing error, parity error and transmission finished. A CPU port reads all eight bits in the same cycle, with no wait states, and writes them back under a mask.

Five of the flags cannot be cleared by a blind write. The CPU first reads the register while the flag is 1, which arms that flag. A later write with a 0 in the flag's position then clears it. A hardware set event cancels the arming. A DMA write strobe to the transmit data register also clears the transmit-empty flag. A transmit-enable level input holds that flag at 1 while the transmitter is off. Reset and a standby request both load the initial value.

Top module: `sci_status_reg`

## Requirements
- R1: `cpu_rdata` always shows the register in the same cycle, with this bit order: 7 tx_empty, 6 rx_full, 5 overrun, 4 frame_err, 3 parity_err, 2 tx_done, 1 mp_rx, 0 mp_tx.
- R2: An active-low reset, or a one-cycle `standby` pulse, gives the value 0x84 after the next edge.
- R3: In bits 7 to 3, a CPU write of 1 has no effect. A CPU write of 0 to a flag that was not read as 1 since it was last set also has no effect.
- R4: If a CPU read (`cpu_rd`) sees one of bits 7 to 3 as 1, a later CPU write with 0 in that bit clears it at the write edge. Other bits are not affected.
- R5: When a set event and a clear (CPU or DMA) reach the same flag in one cycle, the flag stays 1.
- R6: CPU writes never change bits 2 and 1. On `ev_rx_done`, bit 1 takes the value of `rx_mpb_in`.
- R7: Bit 7 is set by `ev_tx_load`, and it is set every cycle that `tx_en` is 0.
- R8: A `dma_txd_wr` pulse clears bit 7.
- R9: Bit 0 is a plain read/write bit loaded from `cpu_wdata[0]` on every CPU write.
- R10: `ev_tx_end` sets bit 2. Bit 2 clears on the edge where bit 7 is cleared.
- R11: A set event on a flag that is already armed disarms it. A CPU read is then needed again before a write of 0 can clear the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| standby | input | 1 | Synchronous reinitialisation request |
| tx_en | input | 1 | Transmitter enable level |
| cpu_rd | input | 1 | CPU read cycle of this register |
| cpu_wr | input | 1 | CPU write cycle of this register |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Current register value |
| dma_txd_wr | input | 1 | DMA write to transmit data register |
| ev_tx_load | input | 1 | Transmit data moved into shifter |
| ev_rx_done | input | 1 | Receive complete |
| ev_overrun | input | 1 | Receive overrun detected |
| ev_frame_err | input | 1 | Framing error detected |
| ev_parity_err | input | 1 | Parity error detected |
| ev_tx_end | input | 1 | Transmission finished |
| rx_mpb_in | input | 1 | Received multiprocessor bit |

## Verification
Every bit of state except the per-flag arming latches is visible at `cpu_rdata` in the cycle after it changes. A wrong flag value therefore shows at the port one edge after the event that caused it. A wrong arming latch stays hidden until the next CPU write of 0. It then shows as a flag that clears when it should hold, or holds when it should clear. For this reason the tests pair each read/write sequence with set events, DMA strobes and blind writes, and then check the flag bits right after the write edge.

// File: rtl/sci_stat_pkg.sv
package sci_stat_pkg;
   localparam int unsigned STAT_W     = 8;
   localparam int unsigned N_ARMED    = 5;
   localparam int unsigned ARMED_LSB  = 3;   // armed flags occupy bits 7..3
   localparam int unsigned B_TXEMPTY  = 7;
   localparam int unsigned B_RXFULL   = 6;
   localparam int unsigned B_OVERRUN  = 5;
   localparam int unsigned B_FRAMEERR = 4;
   localparam int unsigned B_PARERR   = 3;
   localparam int unsigned B_TXDONE   = 2;
   localparam int unsigned B_MPRX     = 1;
   localparam int unsigned B_MPTX     = 0;
   localparam logic [STAT_W-1:0] STAT_INIT = 8'h84;
endpackage

// File: rtl/armed_flag_cell.sv
module armed_flag_cell #(
   parameter bit RST_VAL  = 1'b0,
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic init,
   input  logic set_ev,
   input  logic hw_clr,
   input  logic rd,
   input  logic wr,
   input  logic wbit,
   output logic flag_o,
   output logic clr_take
);
   logic flag_q, armed_q;
   logic cpu_clr, any_clr, flag_d;

   assign cpu_clr = wr && !wbit && armed_q;
   assign any_clr = cpu_clr || hw_clr;

   generate
      if (SET_WINS) begin : g_set_pri
         assign flag_d   = set_ev ? 1'b1 : (any_clr ? 1'b0 : flag_q);
         assign clr_take = any_clr && !set_ev && flag_q;
      end else begin : g_clr_pri
         assign flag_d   = any_clr ? 1'b0 : (set_ev ? 1'b1 : flag_q);
         assign clr_take = any_clr && flag_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q  <= RST_VAL;
         armed_q <= 1'b0;
      end else if (init) begin
         flag_q  <= RST_VAL;
         armed_q <= 1'b0;
      end else begin
         flag_q <= flag_d;
         if (set_ev || !flag_d)
            armed_q <= 1'b0;
         else if (rd && flag_q)
            armed_q <= 1'b1;
      end
   end

   assign flag_o = flag_q;

   AST_UNARMED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q && !armed_q && !hw_clr && !init |=> flag_q); // R3
   AST_ARM_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed_q) |-> $past(rd && flag_q)); // R4
   AST_REARM_AFTER_SET: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev |=> !armed_q); // R11
   generate
      if (SET_WINS) begin : g_set_chk
         AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_ev && !init |=> flag_q); // R5
      end
   endgenerate
endmodule

// File: rtl/sci_mp_bits.sv
module sci_mp_bits (
   input  logic clk,
   input  logic rst_n,
   input  logic init,
   input  logic rx_done,
   input  logic mpb_in,
   input  logic wr,
   input  logic wbit0,
   input  logic tx_end,
   input  logic empty_clr,
   output logic mp_rx,
   output logic mp_tx,
   output logic tx_done
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mp_rx   <= 1'b0;
         mp_tx   <= 1'b0;
         tx_done <= 1'b1;
      end else if (init) begin
         mp_rx   <= 1'b0;
         mp_tx   <= 1'b0;
         tx_done <= 1'b1;
      end else begin
         if (rx_done) mp_rx <= mpb_in;
         if (wr)      mp_tx <= wbit0;
         if (tx_end)         tx_done <= 1'b1;
         else if (empty_clr) tx_done <= 1'b0;
      end
   end

   AST_MPRX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_done && !init |=> $stable(mp_rx)); // R6
   AST_TXDONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      tx_end |=> tx_done); // R10
endmodule

// File: rtl/sci_status_reg.sv
module sci_status_reg
   import sci_stat_pkg::*;
#(
   parameter bit FLAG_SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              standby,
   input  logic              tx_en,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   input  logic [STAT_W-1:0] cpu_wdata,
   output logic [STAT_W-1:0] cpu_rdata,
   input  logic              dma_txd_wr,
   input  logic              ev_tx_load,
   input  logic              ev_rx_done,
   input  logic              ev_overrun,
   input  logic              ev_frame_err,
   input  logic              ev_parity_err,
   input  logic              ev_tx_end,
   input  logic              rx_mpb_in
);
   logic [N_ARMED-1:0] set_vec, hwclr_vec, flag_vec, take_vec;
   logic mp_rx, mp_tx, tx_done;

   // index i maps to register bit ARMED_LSB+i
   assign set_vec = {ev_tx_load || !tx_en, ev_rx_done, ev_overrun,
                     ev_frame_err, ev_parity_err};
   assign hwclr_vec = {dma_txd_wr, {(N_ARMED-1){1'b0}}};

   generate
      for (genvar i = 0; i < N_ARMED; i++) begin : g_flag
         localparam int unsigned BITPOS = ARMED_LSB + i;
         armed_flag_cell #(
            .RST_VAL  (STAT_INIT[BITPOS]),
            .SET_WINS (FLAG_SET_WINS)
         ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .init     (standby),
            .set_ev   (set_vec[i]),
            .hw_clr   (hwclr_vec[i]),
            .rd       (cpu_rd),
            .wr       (cpu_wr),
            .wbit     (cpu_wdata[BITPOS]),
            .flag_o   (flag_vec[i]),
            .clr_take (take_vec[i])
         );
      end
   endgenerate

   sci_mp_bits u_mp (
      .clk       (clk),
      .rst_n     (rst_n),
      .init      (standby),
      .rx_done   (ev_rx_done),
      .mpb_in    (rx_mpb_in),
      .wr        (cpu_wr),
      .wbit0     (cpu_wdata[B_MPTX]),
      .tx_end    (ev_tx_end),
      .empty_clr (take_vec[B_TXEMPTY-ARMED_LSB]),
      .mp_rx     (mp_rx),
      .mp_tx     (mp_tx),
      .tx_done   (tx_done)
   );

   assign cpu_rdata = {flag_vec, tx_done, mp_rx, mp_tx};

   AST_STANDBY_INIT: assert property (@(posedge clk) disable iff (!rst_n)
      standby |=> cpu_rdata == STAT_INIT); // R2
   AST_TE_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> cpu_rdata[B_TXEMPTY]); // R7
   AST_DMA_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      dma_txd_wr && tx_en && !ev_tx_load && !standby |=> !cpu_rdata[B_TXEMPTY]); // R8
endmodule

// File: tb/sci_status_reg_bench.sv
module sci_status_reg_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic standby = 0, tx_en = 1, cpu_rd = 0, cpu_wr = 0;
   logic [7:0] cpu_wdata = 8'h00;
   logic [7:0] cpu_rdata;
   logic dma_txd_wr = 0, ev_tx_load = 0, ev_rx_done = 0, ev_overrun = 0;
   logic ev_frame_err = 0, ev_parity_err = 0, ev_tx_end = 0, rx_mpb_in = 0;
   int n_run = 0, n_fail = 0;

   always #10 clk = ~clk;

   sci_status_reg u_sci_status_reg (.*);

   task automatic cyc(); @(negedge clk); endtask

   task automatic check(string req, logic [7:0] mask, logic [7:0] exp);
      n_run++;
      if ((cpu_rdata & mask) !== (exp & mask)) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h (mask %h)", req, cpu_rdata, exp, mask);
      end
   endtask

   task automatic do_read(); cpu_rd = 1; cyc(); cpu_rd = 0; endtask
   task automatic do_write(logic [7:0] d);
      cpu_wdata = d; cpu_wr = 1; cyc(); cpu_wr = 0;
   endtask

   task automatic t_reset();
      check("R2", 8'hFF, 8'h84);
      check("R1", 8'hFF, 8'h84);
   endtask

   task automatic t_blind_writes();
      rx_mpb_in = 1; ev_rx_done = 1; cyc(); ev_rx_done = 0; rx_mpb_in = 0;
      check("R6", 8'hFF, 8'hC6);
      do_write(8'hFF);
      check("R3", 8'hFF, 8'hC7);           // R9 mp_tx set, R6 read-only bits kept
      do_write(8'h00);
      check("R3", 8'hFE, 8'hC6);
      check("R9", 8'h01, 8'h00);
   endtask

   task automatic t_arm_clear();
      do_read();
      do_write(8'hBF);
      check("R4", 8'hFF, 8'h87);
      do_write(8'h00);                     // tx_empty armed by earlier read
      check("R10", 8'hFF, 8'h02);
      ev_tx_load = 1; cyc(); ev_tx_load = 0;
      check("R7", 8'hFF, 8'h82);
      ev_tx_end = 1; cyc(); ev_tx_end = 0;
      check("R10", 8'hFF, 8'h86);
   endtask

   task automatic t_set_wins();
      ev_overrun = 1; cyc(); ev_overrun = 0;
      check("R1", 8'h20, 8'h20);
      do_read();
      ev_overrun = 1; do_write(8'h80); ev_overrun = 0;
      check("R5", 8'h20, 8'h20);
      do_write(8'h80);
      check("R11", 8'h20, 8'h20);
      do_read();
      do_write(8'hDF);
      check("R4", 8'h20, 8'h00);
   endtask

   task automatic t_frame_parity();
      ev_frame_err = 1; ev_parity_err = 1; cyc(); ev_frame_err = 0; ev_parity_err = 0;
      check("R1", 8'h18, 8'h18);
      do_read();
      do_write(8'hF7);
      check("R4", 8'h18, 8'h10);
   endtask

   task automatic t_dma();
      ev_tx_load = 1; cyc(); ev_tx_load = 0;
      ev_tx_end = 1; cyc(); ev_tx_end = 0;
      check("R7", 8'h84, 8'h84);
      dma_txd_wr = 1; cyc(); dma_txd_wr = 0;
      check("R8", 8'h84, 8'h00);
      ev_tx_load = 1; dma_txd_wr = 1; cyc(); ev_tx_load = 0; dma_txd_wr = 0;
      check("R5", 8'h80, 8'h80);
   endtask

   task automatic t_te_low();
      dma_txd_wr = 1; cyc(); dma_txd_wr = 0;
      check("R8", 8'h80, 8'h00);
      tx_en = 0; cyc();
      check("R7", 8'h80, 8'h80);
      dma_txd_wr = 1; cyc(); dma_txd_wr = 0;
      check("R7", 8'h80, 8'h80);
      tx_en = 1; cyc();
   endtask

   task automatic t_standby();
      ev_rx_done = 1; rx_mpb_in = 1; ev_overrun = 1; cyc();
      ev_rx_done = 0; rx_mpb_in = 0; ev_overrun = 0;
      do_write(8'h01);
      standby = 1; cyc(); standby = 0;
      check("R2", 8'hFF, 8'h84);
   endtask

   initial begin
      fork
         begin
            cyc(); cyc(); rst_n = 1; cyc();
            t_reset();
            t_blind_writes();
            t_arm_clear();
            t_set_wins();
            t_frame_parity();
            t_dma();
            t_te_low();
            t_standby();
         end
         begin
            repeat (5000) @(posedge clk);
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule